// File: doc/BRIEF.md
# Block Cipher Host Interface Sequencer

This block is the register-facing front end of a 128-bit block cipher accelerator. Software configures it over a simple word-addressed register bus. The configuration covers the operation (encrypt or decrypt with a key that is already prepared), the chaining mode (ECB or CBC), the key length, the key words and the initialization vector. Software then sets the enable bit. Configuration is frozen while the block is enabled.

For each block, software writes the data-input register four times, most significant word first. On the fourth write the sequencer builds the 128-bit block and, in CBC encryption, XORs it with the running chaining value. It then starts an attached cipher core with a one-cycle start pulse. When the core reports done, the sequencer does three things: it applies the CBC decryption XOR, it updates the chaining value, and it raises a sticky completion flag. Software then reads the result as four data-output words, most significant word first, and clears the flag by writing a self-clearing clear bit. Further blocks run with the same key by repeating write/wait/read.

Register word addresses: 0 control, 1 status, 2 data input, 3 data output, 4..11 key words (address 4 is the most significant key word), 12..15 IV words (address 12 is most significant). Control bits: [0] enable, [2:1] operation (00 encrypt, 10 decrypt), [5:3] chaining (000 ECB, 001 CBC), [6] 256-bit key, [7] flag clear. Status bits: [0] completion, [1] write error, [2] busy.

Top module: `blkc_host_seq`

## Requirements
- R1: After reset, the control and status registers read 0, the data-output register reads 0, and core_start is low.
- R2: While enable (control bit 0) is 1, writes to the key words, the IV words and control bits [6:1] have no effect. Only the enable bit and the clear bit (control bit 7) act.
- R3: Four data-input writes form one block with the first word in bits [127:96]. The fourth write raises core_start for exactly one cycle with that block. core_block is unmodified in ECB.
- R4: Status bit 0 is set when the core returns done and stays set until a control write with bit 7 = 1. Control bit 7 always reads back 0.
- R5: Data-output reads return the result's 32-bit words from most to least significant. A fifth read wraps to the most significant word.
- R6: In CBC encryption (operation 00, chaining 001), the block is XORed with the chaining value before it reaches the core. The core result becomes the next chaining value, so consecutive blocks chain without reconfiguration.
- R7: In CBC decryption (operation 10, chaining 001), the output is the core result XOR the chaining value. The input block becomes the next chaining value, and the first block uses the IV.
- R8: With a reserved chaining code (anything other than 000 or 001) or a reserved operation code (01 or 11), data-input writes start nothing: core_start stays low and status bits 0 and 2 stay 0.
- R9: A data-input write while busy (status bit 2) is ignored and sets status bit 1. The flag clear also clears status bit 1.
- R10: Clearing enable resets the input and output word counters. Setting enable reloads the chaining value from the IV.
- R11: core_decrypt is 1 exactly when the operation field is 10. With control bit 6 = 0, core_key carries key words 0..3 in bits [255:128] and zeros below; with bit 6 = 1, all eight words are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (advances the data-output word counter) |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| core_start | output | 1 | One-cycle start pulse to the cipher core |
| core_decrypt | output | 1 | Core direction: 1 = decrypt |
| core_key | output | 256 | Key presented to the core |
| core_block | output | 128 | Block presented to the core |
| core_done | input | 1 | Core completion pulse |
| core_result | input | 128 | Core output block, valid with core_done |

## Verification
On every cycle the embedded assertions check several properties:
- start is a single-cycle pulse that always coincides with busy, and only occurs under a legal configuration;
- configuration and key state stay frozen while enabled;
- the completion flag holds until it is cleared;
- a write while busy always raises the error bit;
- the input word counter is zero whenever the block is disabled.

Only the bench scenarios can show the data-level results. These are the MSB-first word assembly and readout order, the chaining value carried across consecutive CBC blocks, and a CBC decryption that recovers the plaintext of an earlier encryption. They also cover the IV reload after re-enabling, the restart of a half-written block, and the key-size masking seen through the stand-in core.

// File: rtl/blkc_pkg.sv
package blkc_pkg;
    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 4;
    localparam int BLK_W     = WORD_W * BLK_WORDS;
    localparam int KEY_WORDS = 8;
    localparam int KEY_W     = WORD_W * KEY_WORDS;
    localparam int ADDR_W    = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd1;
    localparam logic [ADDR_W-1:0] A_DIN  = 4'd2;
    localparam logic [ADDR_W-1:0] A_DOUT = 4'd3;
    localparam int KEY_BASE = 4;
    localparam int IV_BASE  = 12;
    localparam int CLR_BIT  = 7;

    localparam logic [1:0] OP_ENC   = 2'b00;
    localparam logic [1:0] OP_DEC   = 2'b10;
    localparam logic [2:0] CH_ECB   = 3'b000;
    localparam logic [2:0] CH_CBC   = 3'b001;

    typedef struct packed {
        logic       key256;
        logic [2:0] chain;
        logic [1:0] op;
        logic       en;
    } ctrl_t;

    localparam int CTRL_BITS = $bits(ctrl_t);

    function automatic logic cfg_legal(ctrl_t c);
        return (c.op == OP_ENC || c.op == OP_DEC) &&
               (c.chain == CH_ECB || c.chain == CH_CBC);
    endfunction

    function automatic logic is_cbc(ctrl_t c);
        return c.chain == CH_CBC;
    endfunction
endpackage

// File: rtl/blkc_cfg_regs.sv
module blkc_cfg_regs
    import blkc_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int NK = KEY_WORDS,
    parameter int NI = BLK_WORDS,
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [W-1:0]    wdata,
    output ctrl_t           cfg,
    output logic            clr_req,
    output logic            en_rise,
    output logic [NK*W-1:0] key_o,
    output logic [NI*W-1:0] iv_o
);
    localparam int HALF = NK / 2;

    logic ctrl_we;
    assign ctrl_we = wr_en && (addr == A_CTRL);
    assign clr_req = ctrl_we && wdata[CLR_BIT];
    assign en_rise = ctrl_we && !cfg.en && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (ctrl_we) begin
            if (!cfg.en) cfg    <= ctrl_t'(wdata[CTRL_BITS-1:0]);
            else         cfg.en <= wdata[0];
        end
    end

    for (genvar i = 0; i < NK; i++) begin : g_key
        logic [W-1:0] kw;
        always_ff @(posedge clk) begin
            if (rst) kw <= '0;
            else if (wr_en && !cfg.en && addr == AW'(KEY_BASE + i)) kw <= wdata;
        end
        if (i < HALF) begin : g_lo
            assign key_o[NK*W-1-i*W -: W] = kw;
        end else begin : g_hi
            assign key_o[NK*W-1-i*W -: W] = cfg.key256 ? kw : '0;
        end
    end

    for (genvar j = 0; j < NI; j++) begin : g_iv
        logic [W-1:0] vw;
        always_ff @(posedge clk) begin
            if (rst) vw <= '0;
            else if (wr_en && !cfg.en && addr == AW'(IV_BASE + j)) vw <= wdata;
        end
        assign iv_o[NI*W-1-j*W -: W] = vw;
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        cfg.en |=> $stable({cfg.key256, cfg.chain, cfg.op}) && $stable(key_o) && $stable(iv_o)); // R2
endmodule

// File: rtl/blkc_din_collect.sv
module blkc_din_collect
    import blkc_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int N = BLK_WORDS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         accept,
    input  logic         busy,
    input  logic         din_we,
    input  logic [W-1:0] wdata,
    output logic         blk_fire,
    output logic [N*W-1:0] blk,
    output logic         werr_set
);
    localparam int CW = $clog2(N);

    logic [CW-1:0]      cnt;
    logic [(N-1)*W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            held <= '0;
        end else if (din_we && accept) begin
            held <= {held[(N-2)*W-1:0], wdata};
            cnt  <= cnt + 1'b1;
        end
    end

    assign blk      = {held, wdata};
    assign blk_fire = din_we && accept && (cnt == CW'(N - 1));
    assign werr_set = din_we && en && busy;

    AST_WCNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> cnt == '0); // R10
endmodule

// File: rtl/blkc_chain_ctl.sv
module blkc_chain_ctl
    import blkc_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int N = BLK_WORDS
) (
    input  logic           clk,
    input  logic           rst,
    input  ctrl_t          cfg,
    input  logic           en_rise,
    input  logic [N*W-1:0] iv,
    input  logic           blk_fire,
    input  logic [N*W-1:0] blk,
    input  logic           clr_req,
    input  logic           werr_set,
    input  logic           dout_rd,
    input  logic           core_done,
    input  logic [N*W-1:0] core_result,
    output logic           core_start,
    output logic [N*W-1:0] core_block,
    output logic           busy,
    output logic           done_flag,
    output logic           werr_flag,
    output logic [W-1:0]   dout_word
);
    localparam int CW = $clog2(N);

    logic [N*W-1:0] chain_q, in_q, out_q;
    logic [CW-1:0]  rcnt;
    logic           enc_cbc, dec_cbc;

    assign enc_cbc = is_cbc(cfg) && (cfg.op == OP_ENC);
    assign dec_cbc = is_cbc(cfg) && (cfg.op == OP_DEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q    <= '0;
            in_q       <= '0;
            out_q      <= '0;
            core_block <= '0;
            core_start <= 1'b0;
            busy       <= 1'b0;
            done_flag  <= 1'b0;
            werr_flag  <= 1'b0;
            rcnt       <= '0;
        end else begin
            core_start <= 1'b0;
            if (en_rise) chain_q <= iv;
            if (clr_req) begin
                done_flag <= 1'b0;
                werr_flag <= 1'b0;
            end
            if (werr_set) werr_flag <= 1'b1;
            if (!cfg.en)      rcnt <= '0;
            else if (dout_rd) rcnt <= rcnt + 1'b1;
            if (blk_fire) begin
                core_block <= enc_cbc ? (blk ^ chain_q) : blk;
                in_q       <= blk;
                core_start <= 1'b1;
                busy       <= 1'b1;
            end
            if (core_done && busy) begin
                busy      <= 1'b0;
                done_flag <= 1'b1;
                rcnt      <= '0;
                out_q     <= dec_cbc ? (core_result ^ chain_q) : core_result;
                if (enc_cbc) chain_q <= core_result;
                if (dec_cbc) chain_q <= in_q;
            end
        end
    end

    always_comb begin
        dout_word = '0;
        for (int k = 0; k < N; k++)
            if (rcnt == CW'(k)) dout_word = out_q[(N-1-k)*W +: W];
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start); // R3
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        core_start |-> busy); // R3
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        done_flag && !clr_req |=> done_flag); // R4
    AST_WERR_SET: assert property (@(posedge clk) disable iff (rst)
        werr_set |=> werr_flag); // R9
endmodule

// File: rtl/blkc_host_seq.sv
module blkc_host_seq
    import blkc_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int N  = BLK_WORDS,
    parameter int NK = KEY_WORDS,
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [AW-1:0]   bus_addr,
    input  logic [W-1:0]    bus_wdata,
    output logic [W-1:0]    bus_rdata,
    output logic            core_start,
    output logic            core_decrypt,
    output logic [NK*W-1:0] core_key,
    output logic [N*W-1:0]  core_block,
    input  logic            core_done,
    input  logic [N*W-1:0]  core_result
);
    ctrl_t          cfg;
    logic           clr_req, en_rise, blk_fire, werr_set;
    logic           busy, done_flag, werr_flag, accept, din_we, dout_rd;
    logic [N*W-1:0] iv, blk;
    logic [W-1:0]   dout_word;

    assign din_we       = bus_wr && (bus_addr == A_DIN);
    assign dout_rd      = bus_rd && (bus_addr == A_DOUT);
    assign accept       = cfg.en && cfg_legal(cfg) && !busy;
    assign core_decrypt = (cfg.op == OP_DEC);

    blkc_cfg_regs #(.W(W), .NK(NK), .NI(N), .AW(AW)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .cfg(cfg), .clr_req(clr_req), .en_rise(en_rise), .key_o(core_key), .iv_o(iv)
    );

    blkc_din_collect #(.W(W), .N(N)) u_din (
        .clk(clk), .rst(rst), .en(cfg.en), .accept(accept), .busy(busy),
        .din_we(din_we), .wdata(bus_wdata), .blk_fire(blk_fire), .blk(blk),
        .werr_set(werr_set)
    );

    blkc_chain_ctl #(.W(W), .N(N)) u_chain (
        .clk(clk), .rst(rst), .cfg(cfg), .en_rise(en_rise), .iv(iv),
        .blk_fire(blk_fire), .blk(blk), .clr_req(clr_req), .werr_set(werr_set),
        .dout_rd(dout_rd), .core_done(core_done), .core_result(core_result),
        .core_start(core_start), .core_block(core_block), .busy(busy),
        .done_flag(done_flag), .werr_flag(werr_flag), .dout_word(dout_word)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = W'(cfg);
            A_STAT:  bus_rdata = W'({busy, werr_flag, done_flag});
            A_DOUT:  bus_rdata = dout_word;
            default: bus_rdata = '0;
        endcase
    end

    AST_RSVD_NO_START: assert property (@(posedge clk) disable iff (rst)
        core_start |-> cfg_legal(cfg)); // R8
endmodule

// File: tb/blkc_host_seq_tb.sv
module blkc_host_seq_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0, bus_rdata;
    logic         core_start, core_decrypt, core_done;
    logic [255:0] core_key;
    logic [127:0] core_block, core_result;

    int vectors = 0, miscompares = 0;
    logic [31:0] kw [8];

    always #2.5 clk = ~clk;

    blkc_host_seq u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_start(core_start),
        .core_decrypt(core_decrypt), .core_key(core_key), .core_block(core_block),
        .core_done(core_done), .core_result(core_result)
    );

    function automatic logic [127:0] fold(logic [255:0] k);
        return k[255:128] ^ k[127:0];
    endfunction
    function automatic logic [127:0] f_enc(logic [127:0] b, logic [127:0] kf);
        logic [127:0] t = b ^ kf;
        return {t[119:0], t[127:120]};
    endfunction
    function automatic logic [127:0] f_dec(logic [127:0] c, logic [127:0] kf);
        return {c[7:0], c[127:8]} ^ kf;
    endfunction

    // stand-in cipher core: fixed latency, reversible
    logic [2:0]   lat;
    logic [127:0] hb;
    logic [255:0] hk;
    logic         hd;
    always @(posedge clk) begin
        core_done <= 1'b0;
        if (rst) begin
            lat <= '0; core_result <= '0;
        end else if (core_start) begin
            lat <= 3'd5; hb <= core_block; hk <= core_key; hd <= core_decrypt;
        end else if (lat != 0) begin
            lat <= lat - 1'b1;
            if (lat == 3'd1) begin
                core_done   <= 1'b1;
                core_result <= hd ? f_dec(hb, fold(hk)) : f_enc(hb, fold(hk));
            end
        end
    end

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] ctl(logic k256, logic [2:0] ch, logic [1:0] op, logic en);
        return {25'd0, k256, ch, op, en};
    endfunction

    function automatic logic [127:0] kfold_model(logic k256);
        logic [255:0] k = {kw[0], kw[1], kw[2], kw[3], kw[4], kw[5], kw[6], kw[7]};
        if (!k256) k[127:0] = '0;
        return fold(k);
    endfunction

    task automatic setup(logic k256, logic [2:0] ch, logic [1:0] op, logic [127:0] iv);
        wr(4'd0, ctl(k256, ch, op, 1'b0));
        for (int i = 0; i < 8; i++) wr(4'(4 + i), kw[i]);
        for (int i = 0; i < 4; i++) wr(4'(12 + i), iv[127 - 32*i -: 32]);
        wr(4'd0, ctl(k256, ch, op, 1'b1));
    endtask

    task automatic wait_done(string req);
        logic [31:0] s;
        for (int i = 0; i < 40; i++) begin
            rd(4'd1, s);
            if (s[0]) return;
        end
        check(req, 128'(s[0]), 128'd1);
    endtask

    task automatic do_block(string req, logic [127:0] din, output logic [127:0] dout);
        logic [31:0] w;
        for (int i = 0; i < 4; i++) wr(4'd2, din[127 - 32*i -: 32]);
        wait_done(req);
        for (int i = 0; i < 4; i++) begin
            rd(4'd3, w); dout[127 - 32*i -: 32] = w;
        end
        wr(4'd0, 32'h81);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(4'd0, v); check("R1 ctrl", 128'(v), 0);
        rd(4'd1, v); check("R1 status", 128'(v), 0);
        rd(4'd3, v); check("R1 dout", 128'(v), 0);
        check("R1 start", 128'(core_start), 0);
    endtask

    task automatic t_ecb_order;
        logic [127:0] pt = 128'h00112233_44556677_8899aabb_ccddeeff, exp;
        logic [31:0] w;
        setup(1'b1, 3'b000, 2'b00, '0);
        exp = f_enc(pt, kfold_model(1'b1));
        for (int i = 0; i < 4; i++) wr(4'd2, pt[127 - 32*i -: 32]);
        wait_done("R3");
        for (int i = 0; i < 4; i++) begin
            rd(4'd3, w); check("R5 word order", 128'(w), 128'(exp[127 - 32*i -: 32]));
        end
        rd(4'd3, w); check("R5 wrap", 128'(w), 128'(exp[127:96]));
        rd(4'd1, w); check("R4 flag sticky", 128'(w[0]), 1);
        wr(4'd0, 32'h81);
        rd(4'd1, w); check("R4 flag cleared", 128'(w[0]), 0);
        rd(4'd0, w); check("R4 clear bit reads 0", 128'(w[7]), 0);
    endtask

    task automatic t_freeze;
        logic [127:0] pt = 128'hcafef00d_12345678_9abcdef0_0badbeef, out, exp;
        logic [31:0] v;
        setup(1'b0, 3'b000, 2'b00, '0);
        exp = f_enc(pt, kfold_model(1'b0));
        wr(4'd4, 32'hffffffff);
        wr(4'd0, ctl(1'b1, 3'b001, 2'b10, 1'b1));
        rd(4'd0, v); check("R2 ctrl frozen", 128'(v), 128'(ctl(1'b0, 3'b000, 2'b00, 1'b1)));
        check("R11 encrypt dir", 128'(core_decrypt), 0);
        do_block("R2", pt, out);
        check("R2 key unchanged", out, exp);
    endtask

    task automatic t_key128;
        logic [127:0] pt = 128'h1, out, exp;
        setup(1'b0, 3'b000, 2'b00, '0);
        check("R11 key128 low zero", core_key[127:0], 0);
        exp = f_enc(pt, kfold_model(1'b0));
        do_block("R11", pt, out);
        check("R11 key128 result", out, exp);
    endtask

    task automatic t_cbc;
        logic [127:0] iv = 128'hfeedface_0f1e2d3c_4b5a6978_deadc0de;
        logic [127:0] p0 = 128'h11111111_22222222_33333333_44444444;
        logic [127:0] p1 = 128'h55555555_66666666_77777777_88888888;
        logic [127:0] c0, c1, o, kf;
        setup(1'b1, 3'b001, 2'b00, iv);
        kf = kfold_model(1'b1);
        do_block("R6", p0, c0); check("R6 first block", c0, f_enc(p0 ^ iv, kf));
        do_block("R6", p1, c1); check("R6 chained block", c1, f_enc(p1 ^ c0, kf));
        wr(4'd0, ctl(1'b1, 3'b001, 2'b00, 1'b0));
        wr(4'd0, ctl(1'b1, 3'b001, 2'b00, 1'b1));
        do_block("R10", p0, o); check("R10 IV reload", o, c0);
        setup(1'b1, 3'b001, 2'b10, iv);
        check("R11 decrypt dir", 128'(core_decrypt), 1);
        do_block("R7", c0, o); check("R7 first block", o, p0);
        do_block("R7", c1, o); check("R7 chained block", o, p1);
    endtask

    task automatic t_reserved;
        logic [31:0] s;
        setup(1'b0, 3'b010, 2'b00, '0);
        for (int i = 0; i < 4; i++) wr(4'd2, 32'h5a5a0000 + 32'(i));
        repeat (10) @(negedge clk);
        rd(4'd1, s); check("R8 chain rsvd", 128'(s & 32'h5), 0);
        setup(1'b0, 3'b000, 2'b01, '0);
        for (int i = 0; i < 4; i++) wr(4'd2, 32'h5a5a0000 + 32'(i));
        repeat (10) @(negedge clk);
        rd(4'd1, s); check("R8 op rsvd", 128'(s & 32'h5), 0);
    endtask

    task automatic t_busy_write;
        logic [127:0] pt = 128'hdeadbeef_01020304_a0b0c0d0_99887766, out;
        logic [31:0] s;
        setup(1'b0, 3'b000, 2'b00, '0);
        for (int i = 0; i < 4; i++) wr(4'd2, pt[127 - 32*i -: 32]);
        wr(4'd2, 32'h0);
        rd(4'd1, s); check("R9 werr set", 128'(s[1]), 1);
        wait_done("R9");
        for (int i = 0; i < 4; i++) begin
            rd(4'd3, s); out[127 - 32*i -: 32] = s;
        end
        check("R9 write ignored", out, f_enc(pt, kfold_model(1'b0)));
        wr(4'd0, 32'h81);
        rd(4'd1, s); check("R9 werr cleared", 128'(s[1]), 0);
        // a later block starts cleanly at the MSB word
        do_block("R9", pt, out); check("R9 counter intact", out, f_enc(pt, kfold_model(1'b0)));
    endtask

    task automatic t_restart;
        logic [127:0] pt = 128'h0a0b0c0d_10203040_55aa55aa_77777777, out;
        setup(1'b0, 3'b000, 2'b00, '0);
        wr(4'd2, 32'h12121212); wr(4'd2, 32'h34343434);
        wr(4'd0, ctl(1'b0, 3'b000, 2'b00, 1'b0));
        wr(4'd0, ctl(1'b0, 3'b000, 2'b00, 1'b1));
        do_block("R10", pt, out);
        check("R10 counter restart", out, f_enc(pt, kfold_model(1'b0)));
    endtask

    initial begin
        for (int i = 0; i < 8; i++) kw[i] = 32'h9e3779b9 * 32'(i + 1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ecb_order();
        t_freeze();
        t_key128();
        t_cbc();
        t_reserved();
        t_busy_write();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule